// File: doc/BRIEF.md
# Multi-Queue Grid Dispatcher

This block takes grid descriptors, each tagged with a stream number, and places them in queues. It starts each grid on a free execution slot and frees the slot when that slot reports completion. By default every stream has its own small FIFO, so grids of unrelated streams run side by side and only grids of the same stream wait for each other. A mode pin switches the block to one shared FIFO for all streams. In that mode the oldest waiting grid blocks everything queued behind it, and at most a fixed number of grids may be in flight.

The submit and issue sides are valid/ready streams. A submit transfers on a cycle where `sub_valid` and `sub_ready` are both high. `sub_ready` drops when the queue that the offered item would enter is full. An offered issue transfers when `iss_ready` is high. While `iss_ready` is low, `iss_valid` and the whole issue payload stay frozen. The completion side takes no back-pressure: any cycle with `cpl_valid` high is taken. `single_mode` is a plain control pin and may only change while the block is empty and idle.

Top module: `grid_dispatcher`

## Requirements
- R1: Grids of one stream issue in submission order. A grid issues only in a cycle after the completion of the previous grid of its stream has been taken.
- R2: In per-stream mode (`single_mode`=0), a grid whose own stream is idle issues even if another stream's grid is blocked. Up to 32 grids (one per stream) may be active at once.
- R3: In per-stream mode, a round-robin pointer chooses among the streams whose queue head may issue. The search starts at the stream after the last one granted, wraps from 31 to 0, and allows at most one issue per cycle.
- R4: An issue goes to the lowest-numbered idle slot. A completion frees its slot at the end of the cycle in which it arrives, and that slot may be chosen again in the next cycle.
- R5: While `iss_valid` is high and `iss_ready` is low, the next cycle shows `iss_valid` high with `iss_stream`, `iss_slot` and `iss_desc` unchanged.
- R6: `sub_ready` is low exactly when the target queue is full. In per-stream mode the target is the queue of `sub_stream` (2 entries each). In shared mode it is the shared FIFO (4 entries). An item offered while `sub_ready` is low is not stored.
- R7: In shared mode, only the head of the shared FIFO may issue. While the head's stream still has a grid active, no later entry issues, whatever its stream.
- R8: In shared mode, no issue occurs while 16 grids are active. In per-stream mode all 32 slots can be filled.
- R9: A completion naming a slot that is not active has no effect.
- R10: During and straight after reset, `iss_valid` is low and `sub_ready` is high. All slots and queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| single_mode | input | 1 | 0: one queue per stream; 1: one shared queue |
| sub_valid | input | 1 | Submit item offered |
| sub_ready | output | 1 | Target queue can accept the offered item |
| sub_stream | input | 5 | Stream number of the offered item |
| sub_desc | input | 16 | Grid descriptor of the offered item |
| iss_valid | output | 1 | A grid is offered to a slot |
| iss_ready | input | 1 | Slot side accepts the offered grid |
| iss_stream | output | 5 | Stream of the offered grid |
| iss_slot | output | 5 | Slot the offered grid will occupy |
| iss_desc | output | 16 | Descriptor of the offered grid |
| cpl_valid | input | 1 | A slot reports its grid finished |
| cpl_slot | input | 5 | Slot that finished |

## Verification
A stale stream-busy flag shows at the ports within one cycle. It either issues a second grid of a stream before the first completes, or it withholds a grid that should issue in the cycle after its predecessor's completion. A wrong slot table shows as an issue onto an occupied slot, or as a freed slot that is not reused in the next cycle. A drifting round-robin pointer shows the first time two streams compete. A bad queue counter shows as `sub_ready` falling too early or too late, or as a descriptor issued out of order.

// File: rtl/grid_disp_pkg.sv
package grid_disp_pkg;
  typedef enum logic {
    QM_PER_STREAM = 1'b0,
    QM_SHARED     = 1'b1
  } qmode_e;
endpackage

// File: rtl/gd_fifo.sv
module gd_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign dout  = mem[rd_q];

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push && !full) wr_q <= adv(wr_q);
      if (pop && !empty) rd_q <= adv(rd_q);
      case ({push && !full, pop && !empty})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/gd_rr_arb.sv
module gd_rr_arb #(
  parameter int N = 32
) (
  input  logic [N-1:0]         req,
  input  logic [$clog2(N)-1:0] start,
  output logic                 grant_v,
  output logic [$clog2(N)-1:0] grant_idx
);
  localparam int IW = $clog2(N);

  logic [IW:0] pos;

  always_comb begin
    grant_v   = 1'b0;
    grant_idx = '0;
    pos       = '0;
    for (int off = 0; off < N; off++) begin
      pos = {1'b0, start} + (IW+1)'(off);
      if (pos >= (IW+1)'(N)) pos = pos - (IW+1)'(N);
      if (!grant_v && req[pos[IW-1:0]]) begin
        grant_v   = 1'b1;
        grant_idx = pos[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/gd_slot_pool.sv
module gd_slot_pool #(
  parameter int NSLOT = 32,
  parameter int SW    = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc,
  input  logic [$clog2(NSLOT)-1:0] alloc_slot,
  input  logic [SW-1:0]            alloc_sid,
  input  logic                     cpl_v,
  input  logic [$clog2(NSLOT)-1:0] cpl_slot,
  output logic                     free_v,
  output logic [$clog2(NSLOT)-1:0] free_slot,
  output logic [$clog2(NSLOT+1)-1:0] active_cnt,
  output logic                     rel_v,
  output logic [SW-1:0]            rel_sid
);
  localparam int LW = $clog2(NSLOT);
  localparam int CW = $clog2(NSLOT + 1);

  logic [NSLOT-1:0] busy_q;
  logic [SW-1:0]    sid_q [NSLOT];

  assign rel_v   = cpl_v && busy_q[cpl_slot];
  assign rel_sid = sid_q[cpl_slot];
  assign free_v  = ~&busy_q;

  always_comb begin
    free_slot  = '0;
    active_cnt = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (!busy_q[i]) free_slot = LW'(i);
    end
    for (int i = 0; i < NSLOT; i++) begin
      active_cnt = active_cnt + CW'(busy_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int i = 0; i < NSLOT; i++) sid_q[i] <= '0;
    end else begin
      if (alloc) begin
        busy_q[alloc_slot] <= 1'b1;
        sid_q[alloc_slot]  <= alloc_sid;
      end
      if (rel_v) busy_q[cpl_slot] <= 1'b0;
    end
  end
endmodule

// File: rtl/grid_dispatcher.sv
module grid_dispatcher
  import grid_disp_pkg::*;
#(
  parameter int NUM_STREAMS = 32,
  parameter int STREAM_DEPTH = 2,
  parameter int NUM_SLOTS   = 32,
  parameter int SHARED_DEPTH = 4,
  parameter int SQ_CAP      = 16,
  parameter int DESC_W      = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           single_mode,
  input  logic                           sub_valid,
  output logic                           sub_ready,
  input  logic [$clog2(NUM_STREAMS)-1:0] sub_stream,
  input  logic [DESC_W-1:0]              sub_desc,
  output logic                           iss_valid,
  input  logic                           iss_ready,
  output logic [$clog2(NUM_STREAMS)-1:0] iss_stream,
  output logic [$clog2(NUM_SLOTS)-1:0]   iss_slot,
  output logic [DESC_W-1:0]              iss_desc,
  input  logic                           cpl_valid,
  input  logic [$clog2(NUM_SLOTS)-1:0]   cpl_slot
);
  localparam int SW  = $clog2(NUM_STREAMS);
  localparam int LW  = $clog2(NUM_SLOTS);
  localparam int CW  = $clog2(NUM_SLOTS + 1);
  localparam int SQW = SW + DESC_W;

  qmode_e mode;
  assign mode = qmode_e'(single_mode);

  logic              fire;
  logic              sub_fire;
  logic [SW-1:0]     sel_stream;
  logic [LW-1:0]     sel_slot;

  // per-stream queues
  logic [NUM_STREAMS-1:0] q_empty, q_full, q_push, q_pop;
  logic [DESC_W-1:0]      head_d [NUM_STREAMS];

  assign sub_fire = sub_valid && sub_ready;

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_sq
    assign q_push[s] = sub_fire && (mode == QM_PER_STREAM) && (sub_stream == SW'(s));
    assign q_pop[s]  = fire && (mode == QM_PER_STREAM) && (sel_stream == SW'(s));
    gd_fifo #(.W(DESC_W), .DEPTH(STREAM_DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n),
      .push(q_push[s]), .din(sub_desc),
      .pop(q_pop[s]), .dout(head_d[s]),
      .empty(q_empty[s]), .full(q_full[s])
    );
  end

  // shared queue
  logic           sh_empty, sh_full;
  logic [SQW-1:0] sh_dout;
  logic [SW-1:0]  sh_sid;

  gd_fifo #(.W(SQW), .DEPTH(SHARED_DEPTH)) u_shared (
    .clk(clk), .rst_n(rst_n),
    .push(sub_fire && (mode == QM_SHARED)), .din({sub_stream, sub_desc}),
    .pop(fire && (mode == QM_SHARED)), .dout(sh_dout),
    .empty(sh_empty), .full(sh_full)
  );
  assign sh_sid = sh_dout[SQW-1:DESC_W];

  assign sub_ready = (mode == QM_SHARED) ? !sh_full : !q_full[sub_stream];

  // slot pool
  logic          free_v, rel_v;
  logic [LW-1:0] free_slot;
  logic [CW-1:0] active_cnt;
  logic [SW-1:0] rel_sid;

  gd_slot_pool #(.NSLOT(NUM_SLOTS), .SW(SW)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .alloc(fire), .alloc_slot(sel_slot), .alloc_sid(sel_stream),
    .cpl_v(cpl_valid), .cpl_slot(cpl_slot),
    .free_v(free_v), .free_slot(free_slot), .active_cnt(active_cnt),
    .rel_v(rel_v), .rel_sid(rel_sid)
  );

  // stream activity and arbitration
  logic [NUM_STREAMS-1:0] strm_busy_q, cand;
  logic [SW-1:0]          rr_q, arb_idx;
  logic                   arb_v, sh_ok;

  assign cand = ~q_empty & ~strm_busy_q;

  gd_rr_arb #(.N(NUM_STREAMS)) u_arb (
    .req(cand), .start(rr_q), .grant_v(arb_v), .grant_idx(arb_idx)
  );

  assign sh_ok = !sh_empty && !strm_busy_q[sh_sid] && (active_cnt < CW'(SQ_CAP));

  // issue stage with stall hold
  logic          hold_q;
  logic [SW-1:0] hold_sid_q;
  logic [LW-1:0] hold_slot_q;

  always_comb begin
    if (hold_q) begin
      iss_valid  = 1'b1;
      sel_stream = hold_sid_q;
      sel_slot   = hold_slot_q;
    end else begin
      iss_valid  = free_v && ((mode == QM_SHARED) ? sh_ok : arb_v);
      sel_stream = (mode == QM_SHARED) ? sh_sid : arb_idx;
      sel_slot   = free_slot;
    end
  end

  assign iss_stream = sel_stream;
  assign iss_slot   = sel_slot;
  assign iss_desc   = (mode == QM_SHARED) ? sh_dout[DESC_W-1:0] : head_d[sel_stream];
  assign fire       = iss_valid && iss_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q      <= 1'b0;
      hold_sid_q  <= '0;
      hold_slot_q <= '0;
      rr_q        <= '0;
      strm_busy_q <= '0;
    end else begin
      hold_q <= iss_valid && !iss_ready;
      if (iss_valid && !iss_ready) begin
        hold_sid_q  <= sel_stream;
        hold_slot_q <= sel_slot;
      end
      if (fire && (mode == QM_PER_STREAM))
        rr_q <= (sel_stream == SW'(NUM_STREAMS - 1)) ? '0 : sel_stream + 1'b1;
      if (fire)  strm_busy_q[sel_stream] <= 1'b1;
      if (rel_v) strm_busy_q[rel_sid]    <= 1'b0;
    end
  end
endmodule

// File: rtl/grid_dispatcher_chk.sv
module grid_dispatcher_chk #(
  parameter int NUM_STREAMS = 32,
  parameter int NUM_SLOTS   = 32,
  parameter int SQ_CAP      = 16,
  parameter int DESC_W      = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           single_mode,
  input logic                           iss_valid,
  input logic                           iss_ready,
  input logic [$clog2(NUM_STREAMS)-1:0] iss_stream,
  input logic [$clog2(NUM_SLOTS)-1:0]   iss_slot,
  input logic [DESC_W-1:0]              iss_desc,
  input logic                           cpl_valid,
  input logic [$clog2(NUM_SLOTS)-1:0]   cpl_slot
);
  localparam int SW = $clog2(NUM_STREAMS);

  logic [NUM_SLOTS-1:0]   ck_busy;
  logic [SW-1:0]          ck_sid [NUM_SLOTS];
  logic [NUM_STREAMS-1:0] ck_sact;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_busy <= '0;
      ck_sact <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) ck_sid[i] <= '0;
    end else begin
      if (iss_valid && iss_ready) begin
        ck_busy[iss_slot]   <= 1'b1;
        ck_sid[iss_slot]    <= iss_stream;
        ck_sact[iss_stream] <= 1'b1;
      end
      if (cpl_valid && ck_busy[cpl_slot]) begin
        ck_busy[cpl_slot]         <= 1'b0;
        ck_sact[ck_sid[cpl_slot]] <= 1'b0;
      end
    end
  end

  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_stream)
                                   && $stable(iss_slot) && $stable(iss_desc)));

  p_slot_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !ck_busy[iss_slot]);

  p_stream_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> !ck_sact[iss_stream]);

  p_shared_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    single_mode |-> ($countones(ck_busy) <= SQ_CAP));
endmodule

bind grid_dispatcher grid_dispatcher_chk #(
  .NUM_STREAMS(NUM_STREAMS), .NUM_SLOTS(NUM_SLOTS),
  .SQ_CAP(SQ_CAP), .DESC_W(DESC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .single_mode(single_mode),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_stream(iss_stream),
  .iss_slot(iss_slot), .iss_desc(iss_desc),
  .cpl_valid(cpl_valid), .cpl_slot(cpl_slot)
);

// File: tb/sim_grid_dispatcher.sv
`timescale 1ns/1ps
module sim_grid_dispatcher;
  logic        clk = 1'b0;
  logic        rst_n, single_mode;
  logic        sub_valid, sub_ready, iss_valid, iss_ready, cpl_valid;
  logic [4:0]  sub_stream, iss_stream, iss_slot, cpl_slot;
  logic [15:0] sub_desc, iss_desc;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  grid_dispatcher #(
    .NUM_STREAMS(32), .STREAM_DEPTH(2), .NUM_SLOTS(32),
    .SHARED_DEPTH(4), .SQ_CAP(16), .DESC_W(16)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .single_mode(single_mode),
    .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_stream(sub_stream), .sub_desc(sub_desc),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_stream(iss_stream),
    .iss_slot(iss_slot), .iss_desc(iss_desc),
    .cpl_valid(cpl_valid), .cpl_slot(cpl_slot)
  );

  typedef struct packed {
    logic        sv; logic [4:0] ss; logic [15:0] sd;
    logic        cv; logic [4:0] cs; logic rdy;
    logic        ev; logic [4:0] es; logic [4:0] eslot; logic [15:0] ed;
  } vec_t;

  // per-stream mode: ordering (R1), overlap (R2), round-robin (R3), slot reuse (R4), stall hold (R5)
  localparam vec_t TBL [17] = '{
    '{1'b1, 5'd3,  16'h0301, 1'b0, 5'd0, 1'b1, 1'b0, 5'd0,  5'd0, 16'h0000},
    '{1'b1, 5'd3,  16'h0302, 1'b0, 5'd0, 1'b1, 1'b1, 5'd3,  5'd0, 16'h0301},
    '{1'b1, 5'd5,  16'h0501, 1'b0, 5'd0, 1'b1, 1'b0, 5'd0,  5'd0, 16'h0000},
    '{1'b0, 5'd0,  16'h0000, 1'b0, 5'd0, 1'b1, 1'b1, 5'd5,  5'd1, 16'h0501},
    '{1'b0, 5'd0,  16'h0000, 1'b1, 5'd0, 1'b1, 1'b0, 5'd0,  5'd0, 16'h0000},
    '{1'b1, 5'd5,  16'h0502, 1'b0, 5'd0, 1'b1, 1'b1, 5'd3,  5'd0, 16'h0302},
    '{1'b1, 5'd20, 16'h1401, 1'b1, 5'd1, 1'b1, 1'b0, 5'd0,  5'd0, 16'h0000},
    '{1'b0, 5'd0,  16'h0000, 1'b0, 5'd0, 1'b1, 1'b1, 5'd5,  5'd1, 16'h0502},
    '{1'b0, 5'd0,  16'h0000, 1'b0, 5'd0, 1'b1, 1'b1, 5'd20, 5'd2, 16'h1401},
    '{1'b1, 5'd20, 16'h1402, 1'b0, 5'd0, 1'b1, 1'b0, 5'd0,  5'd0, 16'h0000},
    '{1'b1, 5'd2,  16'h0201, 1'b1, 5'd2, 1'b1, 1'b0, 5'd0,  5'd0, 16'h0000},
    '{1'b0, 5'd0,  16'h0000, 1'b0, 5'd0, 1'b1, 1'b1, 5'd2,  5'd2, 16'h0201},
    '{1'b0, 5'd0,  16'h0000, 1'b0, 5'd0, 1'b1, 1'b1, 5'd20, 5'd3, 16'h1402},
    '{1'b1, 5'd7,  16'h0701, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0,  5'd0, 16'h0000},
    '{1'b0, 5'd0,  16'h0000, 1'b1, 5'd0, 1'b0, 1'b1, 5'd7,  5'd4, 16'h0701},
    '{1'b0, 5'd0,  16'h0000, 1'b0, 5'd0, 1'b1, 1'b1, 5'd7,  5'd4, 16'h0701},
    '{1'b0, 5'd0,  16'h0000, 1'b0, 5'd0, 1'b1, 1'b0, 5'd0,  5'd0, 16'h0000}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] iss_word();
    return {35'd0, iss_valid, iss_stream, iss_slot, iss_desc};
  endfunction

  function automatic logic [63:0] exp_word(input logic v, input logic [4:0] s,
                                           input logic [4:0] sl, input logic [15:0] d);
    return {35'd0, v, s, sl, d};
  endfunction

  task automatic expect_iss(input string req, input logic v, input logic [4:0] s,
                            input logic [4:0] sl, input logic [15:0] d);
    if (v) check(iss_word() == exp_word(v, s, sl, d), req, iss_word(), exp_word(v, s, sl, d));
    else   check(iss_valid == 1'b0, req, 64'(iss_valid), 64'd0);
  endtask

  // drive inputs after the falling edge, then let combinational outputs settle
  task automatic drive(input logic sv, input logic [4:0] ss, input logic [15:0] sd,
                       input logic cv, input logic [4:0] cs, input logic rdy);
    @(negedge clk);
    sub_valid = sv; sub_stream = ss; sub_desc = sd;
    cpl_valid = cv; cpl_slot = cs; iss_ready = rdy;
    #1;
  endtask

  task automatic idle(input logic rdy);
    drive(1'b0, 5'd0, 16'h0, 1'b0, 5'd0, rdy);
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_n = 1'b0; single_mode = m;
    sub_valid = 1'b0; sub_stream = '0; sub_desc = '0;
    cpl_valid = 1'b0; cpl_slot = '0; iss_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #800000;
    n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int fired;

    // R10: reset state
    do_reset(1'b0);
    rst_n = 1'b0;
    #1;
    check(iss_valid == 1'b0 && sub_ready == 1'b1, "R10 in reset", {iss_valid, sub_ready}, 64'b01);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1'b1);
    check(iss_valid == 1'b0 && sub_ready == 1'b1, "R10 after reset", {iss_valid, sub_ready}, 64'b01);

    // vector table, per-stream mode (R1 R2 R3 R4 R5)
    do_reset(1'b0);
    for (int i = 0; i < 17; i++) begin
      drive(TBL[i].sv, TBL[i].ss, TBL[i].sd, TBL[i].cv, TBL[i].cs, TBL[i].rdy);
      expect_iss($sformatf("R1/R3/R4/R5 row %0d", i), TBL[i].ev, TBL[i].es, TBL[i].eslot, TBL[i].ed);
    end

    // R6: per-stream queue full drops ready for that stream only
    do_reset(1'b0);
    drive(1'b1, 5'd6, 16'h0601, 1'b0, 5'd0, 1'b0);
    check(sub_ready == 1'b1, "R6 first accept", 64'(sub_ready), 64'd1);
    drive(1'b1, 5'd6, 16'h0602, 1'b0, 5'd0, 1'b0);
    check(sub_ready == 1'b1, "R6 second accept", 64'(sub_ready), 64'd1);
    drive(1'b1, 5'd6, 16'h0603, 1'b0, 5'd0, 1'b0);
    check(sub_ready == 1'b0, "R6 full stream", 64'(sub_ready), 64'd0);
    drive(1'b1, 5'd7, 16'h0701, 1'b0, 5'd0, 1'b0);
    check(sub_ready == 1'b1, "R6 other stream ready", 64'(sub_ready), 64'd1);
    idle(1'b1);
    expect_iss("R5 held grant", 1'b1, 5'd6, 5'd0, 16'h0601);
    drive(1'b0, 5'd0, 16'h0, 1'b1, 5'd0, 1'b1);
    expect_iss("R2 other stream issues", 1'b1, 5'd7, 5'd1, 16'h0701);
    idle(1'b1);
    expect_iss("R1 second grid after completion", 1'b1, 5'd6, 5'd0, 16'h0602);
    drive(1'b0, 5'd0, 16'h0, 1'b1, 5'd0, 1'b1);
    idle(1'b1);
    expect_iss("R6 rejected item not stored", 1'b0, 5'd0, 5'd0, 16'h0);

    // R9: completion to idle slot ignored
    do_reset(1'b0);
    drive(1'b1, 5'd1, 16'h0101, 1'b0, 5'd0, 1'b1);
    drive(1'b1, 5'd1, 16'h0102, 1'b0, 5'd0, 1'b1);
    drive(1'b0, 5'd0, 16'h0, 1'b1, 5'd9, 1'b1);
    idle(1'b1);
    expect_iss("R9 stray completion ignored", 1'b0, 5'd0, 5'd0, 16'h0);
    drive(1'b0, 5'd0, 16'h0, 1'b1, 5'd0, 1'b1);
    idle(1'b1);
    expect_iss("R9/R4 real completion frees", 1'b1, 5'd1, 5'd0, 16'h0102);

    // R2/R8: all 32 slots fill in per-stream mode
    do_reset(1'b0);
    fired = 0;
    for (int s = 0; s < 32; s++) begin
      drive(1'b1, 5'(s), 16'(s), 1'b0, 5'd0, 1'b1);
      if (iss_valid) fired++;
    end
    for (int k = 0; k < 3; k++) begin
      idle(1'b1);
      if (iss_valid) fired++;
    end
    check(fired == 32, "R2/R8 per-stream 32 active", 64'(fired), 64'd32);

    // R8: shared mode caps at 16
    do_reset(1'b1);
    fired = 0;
    for (int s = 0; s < 17; s++) begin
      drive(1'b1, 5'(s), 16'h1000 + 16'(s), 1'b0, 5'd0, 1'b1);
      if (iss_valid) fired++;
    end
    for (int k = 0; k < 3; k++) begin
      idle(1'b1);
      if (iss_valid) fired++;
    end
    check(fired == 16, "R8 shared cap count", 64'(fired), 64'd16);
    drive(1'b0, 5'd0, 16'h0, 1'b1, 5'd0, 1'b1);
    expect_iss("R8 still capped", 1'b0, 5'd0, 5'd0, 16'h0);
    idle(1'b1);
    expect_iss("R8/R4 issue after release", 1'b1, 5'd16, 5'd0, 16'h1010);

    // R7: head-of-line blocking in shared mode
    do_reset(1'b1);
    drive(1'b1, 5'd1, 16'h0101, 1'b0, 5'd0, 1'b1);
    drive(1'b1, 5'd1, 16'h0102, 1'b0, 5'd0, 1'b1);
    drive(1'b1, 5'd2, 16'h0201, 1'b0, 5'd0, 1'b1);
    idle(1'b1);
    expect_iss("R7 blocked behind head", 1'b0, 5'd0, 5'd0, 16'h0);
    idle(1'b1);
    expect_iss("R7 still blocked", 1'b0, 5'd0, 5'd0, 16'h0);
    drive(1'b0, 5'd0, 16'h0, 1'b1, 5'd0, 1'b1);
    idle(1'b1);
    expect_iss("R7 head issues", 1'b1, 5'd1, 5'd0, 16'h0102);
    idle(1'b1);
    expect_iss("R7 follower issues", 1'b1, 5'd2, 5'd1, 16'h0201);

    // R2: same pattern in per-stream mode passes the blocked stream
    do_reset(1'b0);
    drive(1'b1, 5'd1, 16'h0101, 1'b0, 5'd0, 1'b1);
    drive(1'b1, 5'd1, 16'h0102, 1'b0, 5'd0, 1'b1);
    drive(1'b1, 5'd2, 16'h0201, 1'b0, 5'd0, 1'b1);
    idle(1'b1);
    expect_iss("R2 unrelated stream overtakes", 1'b1, 5'd2, 5'd1, 16'h0201);

    idle(1'b0);
    finish_run();
  end
endmodule